// File: doc/BRIEF.md
# Arithmetic Compare-and-Skip Unit

This block is the combinational execute stage for the arithmetic-test instruction group of a 36-bit word machine. Every cycle it takes a 9-bit opcode, the accumulator word, the memory operand word and an 18-bit immediate. From these it produces three things:

- the arithmetic result;
- write-enables that say whether the result goes back to the accumulator or to memory;
- a jump or skip request when the selected condition on the result holds.

The sequencer around the block fetches operands, forms effective addresses, moves the PC and performs the writes. The block itself only decides.

All eight families share one adder. The adder subtracts for compares, adds one for the increment forms, subtracts one for the decrement forms, and passes the operand through for the plain tests. A single condition evaluator then looks at the zero and sign status of that adder output. For compares it uses a sign corrected for overflow, so that "less than" is a true signed comparison. A parameter chooses between a plain ripple adder and a split carry-select adder.

Top module: `atu_top`

## Requirements
- R1: Only opcodes whose top three bits are 011 belong to the group. For any other opcode, jump_req, skip_req, wr_ac and wr_mem are all 0.
- R2: The opcode bits [5:3] select the family:
  - 000: compare with immediate
  - 001: compare with memory
  - 010: test accumulator, jump form
  - 011: test memory, skip form
  - 100: add one to accumulator, jump form
  - 101: add one to memory, skip form
  - 110: subtract one from accumulator, jump form
  - 111: subtract one from memory, skip form

  Both compare families are skip forms.
- R3: For compares, result is the accumulator minus the operand, modulo 2^WORD_W. The operand is mem_in, or imm_in zero-extended to the word width.
- R4: For the plain test families, result equals the tested word (ac_in or mem_in) unchanged.
- R5: For the add-one and subtract-one families, result is the tested word plus or minus one, modulo 2^WORD_W. The most positive value wraps to the most negative value, and the reverse.
- R6: The opcode bits [2:0] select the condition:
  - 000: never
  - 001: less
  - 010: equal
  - 011: less-or-equal
  - 100: always
  - 101: greater-or-equal
  - 110: not-equal
  - 111: greater
- R7: For compares, "less" and "equal" are the signed two's-complement relation between the accumulator and the operand. This holds even when the subtraction overflows.
- R8: For the non-compare families, "less" means result is negative and "equal" means result is zero.
- R9: The add-one and subtract-one jump forms raise wr_ac, and their skip forms raise wr_mem. No other family raises either signal.
- R10: A jump form raises jump_req when its condition holds, and a skip form raises skip_req. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 9 | Instruction opcode: group prefix, family, condition |
| ac_in | input | WORD_W | Accumulator word |
| mem_in | input | WORD_W | Memory operand word |
| imm_in | input | IMM_W | Immediate operand, zero-extended for compares |
| result | output | WORD_W | Arithmetic result of the selected family |
| wr_ac | output | 1 | Result is to be written to the accumulator |
| wr_mem | output | 1 | Result is to be written to memory |
| jump_req | output | 1 | Jump condition satisfied |
| skip_req | output | 1 | Skip condition satisfied |

## Verification
Two things are decided from one opcode and can be active together: the write-back of a modified value and the jump or skip decision on that same modified value. The increment and decrement families provoke this case on both wrap boundaries. In those cases the bench checks the write-enable, the wrapped result and the request in the same sample, and compares all three against its own arithmetic model. The compare families are swept across operand pairs whose differences overflow. That sweep separates a correct signed relation from the raw sign of the difference.

// File: rtl/atu_pkg.sv
package atu_pkg;

   localparam int unsigned OPC_W = 9;
   localparam logic [2:0] GROUP_PREFIX = 3'b011;

   typedef enum logic [2:0] {
      FAM_CMP_IMM = 3'b000,
      FAM_CMP_MEM = 3'b001,
      FAM_TST_AC  = 3'b010,
      FAM_TST_MEM = 3'b011,
      FAM_INC_AC  = 3'b100,
      FAM_INC_MEM = 3'b101,
      FAM_DEC_AC  = 3'b110,
      FAM_DEC_MEM = 3'b111
   } fam_e;

   typedef enum logic [1:0] {
      B_ZERO = 2'd0,
      B_ONE  = 2'd1,
      B_MEM  = 2'd2,
      B_IMM  = 2'd3
   } bsel_e;

   typedef struct packed {
      logic  active;
      logic  is_cmp;
      logic  a_from_mem;
      bsel_e b_sel;
      logic  subtract;
      logic  wr_ac;
      logic  wr_mem;
      logic  is_jump;
   } ctl_t;

endpackage

// File: rtl/atu_decode.sv
module atu_decode
   import atu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output ctl_t             ctl,
   output logic [2:0]       cond
);
   fam_e fam;

   always_comb begin
      fam  = fam_e'(opcode[5:3]);
      cond = opcode[2:0];
      ctl  = '0;
      ctl.active = (opcode[8:6] == GROUP_PREFIX);
      unique case (fam)
         FAM_CMP_IMM: begin
            ctl.is_cmp   = 1'b1;
            ctl.b_sel    = B_IMM;
            ctl.subtract = 1'b1;
         end
         FAM_CMP_MEM: begin
            ctl.is_cmp   = 1'b1;
            ctl.b_sel    = B_MEM;
            ctl.subtract = 1'b1;
         end
         FAM_TST_AC: begin
            ctl.b_sel   = B_ZERO;
            ctl.is_jump = 1'b1;
         end
         FAM_TST_MEM: begin
            ctl.a_from_mem = 1'b1;
            ctl.b_sel      = B_ZERO;
         end
         FAM_INC_AC: begin
            ctl.b_sel   = B_ONE;
            ctl.wr_ac   = 1'b1;
            ctl.is_jump = 1'b1;
         end
         FAM_INC_MEM: begin
            ctl.a_from_mem = 1'b1;
            ctl.b_sel      = B_ONE;
            ctl.wr_mem     = 1'b1;
         end
         FAM_DEC_AC: begin
            ctl.b_sel    = B_ONE;
            ctl.subtract = 1'b1;
            ctl.wr_ac    = 1'b1;
            ctl.is_jump  = 1'b1;
         end
         FAM_DEC_MEM: begin
            ctl.a_from_mem = 1'b1;
            ctl.b_sel      = B_ONE;
            ctl.subtract   = 1'b1;
            ctl.wr_mem     = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/atu_datapath.sv
module atu_datapath
   import atu_pkg::*;
#(
   parameter int unsigned WORD_W       = 36,
   parameter int unsigned IMM_W        = 18,
   parameter bit          CARRY_SELECT = 1'b0
)(
   input  logic              a_from_mem,
   input  bsel_e             b_sel,
   input  logic              subtract,
   input  logic [WORD_W-1:0] ac_in,
   input  logic [WORD_W-1:0] mem_in,
   input  logic [IMM_W-1:0]  imm_in,
   output logic [WORD_W-1:0] sum,
   output logic              ovf
);
   localparam int unsigned LO_W = WORD_W / 2;
   localparam int unsigned HI_W = WORD_W - LO_W;
   localparam int unsigned PAD_W = WORD_W - IMM_W;

   logic [WORD_W-1:0] op_a;
   logic [WORD_W-1:0] op_b;
   logic [WORD_W-1:0] op_b_eff;

   always_comb begin
      op_a = a_from_mem ? mem_in : ac_in;
      unique case (b_sel)
         B_ZERO:  op_b = '0;
         B_ONE:   op_b = {{(WORD_W-1){1'b0}}, 1'b1};
         B_MEM:   op_b = mem_in;
         default: op_b = {{PAD_W{1'b0}}, imm_in};
      endcase
      op_b_eff = op_b ^ {WORD_W{subtract}};
   end

   generate
      if (CARRY_SELECT) begin : g_csel
         logic [LO_W:0]   lo_ext;
         logic [HI_W-1:0] hi_c0;
         logic [HI_W-1:0] hi_c1;
         always_comb begin
            lo_ext = {1'b0, op_a[LO_W-1:0]} + {1'b0, op_b_eff[LO_W-1:0]}
                   + {{LO_W{1'b0}}, subtract};
            hi_c0  = op_a[WORD_W-1:LO_W] + op_b_eff[WORD_W-1:LO_W];
            hi_c1  = op_a[WORD_W-1:LO_W] + op_b_eff[WORD_W-1:LO_W]
                   + {{(HI_W-1){1'b0}}, 1'b1};
            sum    = {lo_ext[LO_W] ? hi_c1 : hi_c0, lo_ext[LO_W-1:0]};
         end
      end else begin : g_ripple
         always_comb begin
            sum = op_a + op_b_eff + {{(WORD_W-1){1'b0}}, subtract};
         end
      end
   endgenerate

   always_comb begin
      ovf = (op_a[WORD_W-1] == op_b_eff[WORD_W-1])
         && (sum[WORD_W-1] != op_a[WORD_W-1]);
   end
endmodule

// File: rtl/atu_cond.sv
module atu_cond #(
   parameter int unsigned WORD_W = 36
)(
   input  logic [2:0]        cond,
   input  logic              is_cmp,
   input  logic [WORD_W-1:0] sum,
   input  logic              ovf,
   output logic              hit
);
   logic is_zero;
   logic is_less;
   logic base;

   always_comb begin
      is_zero = (sum == '0);
      is_less = is_cmp ? (sum[WORD_W-1] ^ ovf) : sum[WORD_W-1];
      unique case (cond[1:0])
         2'b00:   base = 1'b0;
         2'b01:   base = is_less;
         2'b10:   base = is_zero;
         default: base = is_less | is_zero;
      endcase
      hit = base ^ cond[2];
   end
endmodule

// File: rtl/atu_top.sv
module atu_top
   import atu_pkg::*;
#(
   parameter int unsigned WORD_W       = 36,
   parameter int unsigned IMM_W        = 18,
   parameter bit          CARRY_SELECT = 1'b0
)(
   input  logic [8:0]        opcode,
   input  logic [WORD_W-1:0] ac_in,
   input  logic [WORD_W-1:0] mem_in,
   input  logic [IMM_W-1:0]  imm_in,
   output logic [WORD_W-1:0] result,
   output logic              wr_ac,
   output logic              wr_mem,
   output logic              jump_req,
   output logic              skip_req
);
   generate
      if (IMM_W >= WORD_W) begin : g_bad_imm
         $error("atu_top: IMM_W must be narrower than WORD_W");
      end
      if (WORD_W < 4) begin : g_bad_word
         $error("atu_top: WORD_W must be at least 4");
      end
   endgenerate

   ctl_t       ctl;
   logic [2:0] cond;
   logic [WORD_W-1:0] sum;
   logic       ovf;
   logic       hit;

   atu_decode u_dec (
      .opcode (opcode),
      .ctl    (ctl),
      .cond   (cond)
   );

   atu_datapath #(
      .WORD_W       (WORD_W),
      .IMM_W        (IMM_W),
      .CARRY_SELECT (CARRY_SELECT)
   ) u_dp (
      .a_from_mem (ctl.a_from_mem),
      .b_sel      (ctl.b_sel),
      .subtract   (ctl.subtract),
      .ac_in      (ac_in),
      .mem_in     (mem_in),
      .imm_in     (imm_in),
      .sum        (sum),
      .ovf        (ovf)
   );

   atu_cond #(.WORD_W(WORD_W)) u_cond (
      .cond   (cond),
      .is_cmp (ctl.is_cmp),
      .sum    (sum),
      .ovf    (ovf),
      .hit    (hit)
   );

   always_comb begin
      result   = sum;
      wr_ac    = ctl.active & ctl.wr_ac;
      wr_mem   = ctl.active & ctl.wr_mem;
      jump_req = ctl.active & hit & ctl.is_jump;
      skip_req = ctl.active & hit & ~ctl.is_jump;
   end
endmodule

// File: rtl/atu_checker.sv
module atu_checker #(
   parameter int unsigned WORD_W = 36,
   parameter int unsigned IMM_W  = 18
)(
   input logic [8:0]        opcode,
   input logic [WORD_W-1:0] ac_in,
   input logic [WORD_W-1:0] mem_in,
   input logic [IMM_W-1:0]  imm_in,
   input logic [WORD_W-1:0] result,
   input logic              wr_ac,
   input logic              wr_mem,
   input logic              jump_req,
   input logic              skip_req
);
   logic known;

   always_comb begin
      known = !$isunknown({opcode, ac_in, mem_in, imm_in,
                           result, wr_ac, wr_mem, jump_req, skip_req});
      if (known) begin
         a_r10_req_exclusive: assert (!(jump_req && skip_req))
            else $error("R10: jump and skip both raised");
         a_r9_wr_exclusive: assert (!(wr_ac && wr_mem))
            else $error("R9: both write targets raised");
         a_r1_outside_idle: assert ((opcode[8:6] == 3'b011) ||
                                    !(jump_req || skip_req || wr_ac || wr_mem))
            else $error("R1: activity outside the group");
         a_r4_test_ac_passes: assert (!(opcode[5:3] == 3'b010) || (result == ac_in))
            else $error("R4: accumulator test altered the value");
         a_r6_never_quiet: assert (!(opcode[2:0] == 3'b000) || !(jump_req || skip_req))
            else $error("R6: never-condition produced a request");
         a_r6_always_fires: assert (!(opcode[8:6] == 3'b011 && opcode[2:0] == 3'b100)
                                    || (jump_req || skip_req))
            else $error("R6: always-condition produced no request");
      end
   end
endmodule

bind atu_top atu_checker #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_chk (
   .opcode   (opcode),
   .ac_in    (ac_in),
   .mem_in   (mem_in),
   .imm_in   (imm_in),
   .result   (result),
   .wr_ac    (wr_ac),
   .wr_mem   (wr_mem),
   .jump_req (jump_req),
   .skip_req (skip_req)
);

// File: tb/tb_atu_top.sv
module tb_atu_top;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 8;
   localparam int IW   = 4;
   localparam int MOD  = 1 << W;
   localparam int HALF = 1 << (W - 1);
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [8:0]    opcode = '0;
   logic [W-1:0]  ac_in  = '0;
   logic [W-1:0]  mem_in = '0;
   logic [IW-1:0] imm_in = '0;
   logic [W-1:0]  result;
   logic wr_ac, wr_mem, jump_req, skip_req;

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;

   atu_top #(.WORD_W(W), .IMM_W(IW), .CARRY_SELECT(1'b1)) dut (
      .opcode   (opcode),
      .ac_in    (ac_in),
      .mem_in   (mem_in),
      .imm_in   (imm_in),
      .result   (result),
      .wr_ac    (wr_ac),
      .wr_mem   (wr_mem),
      .jump_req (jump_req),
      .skip_req (skip_req)
   );

   function automatic int sx(int v);
      return (v >= HALF) ? v - MOD : v;
   endfunction

   function automatic int pick(int i);
      int tbl [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h7e, 8'h7f, 8'h80, 8'h81,
                       8'hfe, 8'hff, 8'h40, 8'hbf, 8'h55, 8'haa, 8'h0f, 8'hf0};
      return tbl[i];
   endfunction

   task automatic report(string req, string what, int got, int exp);
      vectors++;
      if (got != exp) begin
         miscompares++;
         if (miscompares <= 25)
            $display("FAIL %s %s op=%03o ac=%02h mem=%02h imm=%0h got=%0h exp=%0h",
                     req, what, opcode, ac_in, mem_in, imm_in, got, exp);
      end
   endtask

   // Drive one vector after a rising edge, sample at the falling edge.
   task automatic apply(int pre, int fam, int cnd, int a, int m, int im);
      int res, lt, eq, hit, isj, ing, a_op, b_op;
      int e_wac, e_wmem, e_j, e_s;
      string rreq, creq;
      @(posedge clk);
      opcode <= 9'(pre * 64 + fam * 8 + cnd);
      ac_in  <= W'(a);
      mem_in <= W'(m);
      imm_in <= IW'(im);
      @(negedge clk);
      ing = (pre == 3);
      // R2 family map: 0 cmp imm, 1 cmp mem, 2 tst ac, 3 tst mem, 4 inc ac,
      // 5 inc mem, 6 dec ac, 7 dec mem
      lt = 0; eq = 0; res = 0;
      if (fam <= 1) begin
         a_op = a;
         b_op = (fam == 0) ? im : m;
         res  = (a_op - b_op + MOD) % MOD;
         lt   = (sx(a_op) < ((fam == 0) ? im : sx(m))) ? 1 : 0;
         eq   = (a_op == b_op) ? 1 : 0;
         rreq = "R3"; creq = "R7";
      end else begin
         case (fam)
            2: begin res = a; rreq = "R4"; end
            3: begin res = m; rreq = "R4"; end
            4: begin res = (a + 1) % MOD; rreq = "R5"; end
            5: begin res = (m + 1) % MOD; rreq = "R5"; end
            6: begin res = (a + MOD - 1) % MOD; rreq = "R5"; end
            default: begin res = (m + MOD - 1) % MOD; rreq = "R5"; end
         endcase
         lt = (res >= HALF) ? 1 : 0;
         eq = (res == 0) ? 1 : 0;
         creq = "R8";
      end
      // R6 condition map on bits [2:0]
      case (cnd % 4)
         0: hit = 0;
         1: hit = lt;
         2: hit = eq;
         default: hit = lt | eq;
      endcase
      if (cnd >= 4) hit = 1 - hit;
      isj    = (fam == 2 || fam == 4 || fam == 6) ? 1 : 0;
      e_wac  = (ing != 0 && (fam == 4 || fam == 6)) ? 1 : 0;
      e_wmem = (ing != 0 && (fam == 5 || fam == 7)) ? 1 : 0;
      e_j    = ing & hit & isj;
      e_s    = ing & hit & (1 - isj);
      if (ing != 0) begin
         report(rreq, "result", int'(result), res);
         report({creq, "/R6/R10"}, "jump,skip", int'({jump_req, skip_req}), e_j * 2 + e_s);
         report("R9", "wr_ac,wr_mem", int'({wr_ac, wr_mem}), e_wac * 2 + e_wmem);
      end else begin
         report("R1", "flags", int'({jump_req, skip_req, wr_ac, wr_mem}), 0);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         miscompares++;
         $display("FAIL watchdog expired got=%0d exp<=%0d cycles", cycles, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Idle state: all-zero opcode lies outside the group (R1)
      @(negedge clk);
      report("R1", "idle flags", int'({jump_req, skip_req, wr_ac, wr_mem}), 0);
      // Main sweep over the whole group: wrap and overflow corners included (R5, R7)
      for (int fam = 0; fam < 8; fam++)
         for (int cnd = 0; cnd < 8; cnd++)
            for (int i = 0; i < 16; i++)
               for (int j = 0; j < 16; j++)
                  apply(3, fam, cnd, pick(i), pick(j), (i + j) % 16);
      // Outside the group with conditions that would otherwise fire (R1)
      for (int pre = 0; pre < 8; pre++) begin
         if (pre == 3) continue;
         for (int fam = 0; fam < 8; fam++)
            for (int cnd = 0; cnd < 8; cnd++)
               apply(pre, fam, cnd, pick(cnd), pick(fam * 2), fam);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule